// File: doc/BRIEF.md
# Parallel DAC write sequencer

This block sits on the host side of a parallel-input voltage DAC. The DAC has a data bus of 10 or 12 bits, an active-low chip select, an active-low asynchronous clear and an active-low sleep input. The sequencer turns simple requests into pin-level waveforms that meet the converter's timing minimums. Each minimum is given in nanoseconds and converted to system clock cycles from a clock-period parameter.

A shared `req_ready` signal serves three request inputs. `wr_valid` carries a code, `clr_valid` zeroes the converter register, and `sd_valid` with `sd_enter` puts the converter into sleep or wakes it. The converter latches the bus on the rising edge of chip select and is transparent while the strobe is low. The sequencer keeps `shadow_code`, a copy of the code the converter register should hold. After system reset it clears the converter on its own, so the output starts from zero scale.

Top module: `dac_par_seq`

## Requirements
- R1: After `rst_n` is released, `dac_clr_n` stays low and rises on the 5th rising clock edge after release (RESET_CYC at the defaults). During that time `req_ready` is low, `shadow_code` is 0, `dac_cs_n` and `dac_sleep_n` are high.
- R2: Each phase length is the nanosecond minimum divided by `CLK_PERIOD_NS`, rounded up, with a floor of 1. At the defaults (8 ns; 30/45/20/40 ns) this gives setup 4, strobe 6, hold 3 and clear 5 cycles.
- R3: `dac_data` changes only on an accepted write, while `dac_cs_n` is high. It stays unchanged for SETUP_CYC cycles before `dac_cs_n` falls.
- R4: Every write drives `dac_cs_n` low for exactly STROBE_CYC cycles.
- R5: After `dac_cs_n` rises, `dac_data` holds for HOLD_CYC cycles, and `req_ready` returns exactly HOLD_CYC cycles after the rise.
- R6: `req_ready` is high only when idle. A request is taken on a rising edge where `req_ready` and its valid are high and no higher-priority valid is high.
- R7: If `clr_valid` and `wr_valid` are both high, the clear is taken first. The write stays pending and is taken after the clear completes.
- R8: A clear drives `dac_clr_n` low for exactly RESET_CYC cycles and sets `shadow_code` to 0 on the same edge. `dac_cs_n` stays high during the clear.
- R9: A shutdown request with `sd_enter`=1 drives `dac_sleep_n` low; with `sd_enter`=0 it drives it high. It takes one cycle and leaves `req_ready` high. It has the lowest priority.
- R10: Writes and clears work while `dac_sleep_n` is low, and they leave `dac_sleep_n` unchanged.
- R11: When every request has completed, the code latched by the converter equals `shadow_code`. `shadow_code` takes the new code on the edge where `dac_cs_n` rises.
- R12: `dac_data[i]` equals `wr_code[i]` for every bit, with bit 0 the least significant. The width is DATA_W (12 by default, 10 for the narrow part).

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| req_ready | output | 1 | High when a request can be taken |
| wr_valid | input | 1 | Write request |
| wr_code | input | DATA_W | Code to write |
| clr_valid | input | 1 | Clear request (highest priority) |
| sd_valid | input | 1 | Shutdown control request (lowest priority) |
| sd_enter | input | 1 | 1 = enter sleep, 0 = wake |
| dac_data | output | DATA_W | Converter data bus |
| dac_cs_n | output | 1 | Converter chip select, active low |
| dac_clr_n | output | 1 | Converter clear, active low |
| dac_sleep_n | output | 1 | Converter sleep, active low |
| shadow_code | output | DATA_W | Code the converter register should hold |

## Verification
The bench goes after the phase lengths at the cycle level: setup, strobe, hold and clear widths are counted for every operation. A design that got the ceiling wrong would shorten a phase by one cycle and break a nanosecond minimum; a converter model measuring in real time flags that. Two ordering cases are also tested. With a clear and a write raised together, a design without the priority rule would write first and then zero the code. With a write in sleep, a design that gated writes on sleep, or that let the write disturb the sleep line, would leave the latched code or the sleep pin wrong after wake-up. Reusing the same code and issuing a clear while asleep make sure the shadow copy tracks the converter through every path.

// File: rtl/dac_par_seq.sv
module dac_par_seq #(
  parameter int DATA_W        = 12,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_SETUP_NS    = 30,
  parameter int T_STROBE_NS   = 45,
  parameter int T_HOLD_NS     = 20,
  parameter int T_RESET_NS    = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              req_ready,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_code,
  input  logic              clr_valid,
  input  logic              sd_valid,
  input  logic              sd_enter,
  output logic [DATA_W-1:0] dac_data,
  output logic              dac_cs_n,
  output logic              dac_clr_n,
  output logic              dac_sleep_n,
  output logic [DATA_W-1:0] shadow_code
);
  function automatic int to_cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int SETUP_CYC  = to_cyc(T_SETUP_NS);
  localparam int STROBE_CYC = to_cyc(T_STROBE_NS);
  localparam int HOLD_CYC   = to_cyc(T_HOLD_NS);
  localparam int RESET_CYC  = to_cyc(T_RESET_NS);
  localparam int MAX_A      = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_B      = (HOLD_CYC > RESET_CYC) ? HOLD_CYC : RESET_CYC;
  localparam int MAX_CYC    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD, S_CLEAR} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  wire              cnt_done = (cnt == '0);

  assign req_ready = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_CLEAR;
      cnt         <= CNT_W'(RESET_CYC - 1);
      dac_data    <= '0;
      dac_cs_n    <= 1'b1;
      dac_clr_n   <= 1'b0;
      dac_sleep_n <= 1'b1;
      shadow_code <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (clr_valid) begin
            state       <= S_CLEAR;
            cnt         <= CNT_W'(RESET_CYC - 1);
            dac_clr_n   <= 1'b0;
            shadow_code <= '0;
          end else if (wr_valid) begin
            state    <= S_SETUP;
            cnt      <= CNT_W'(SETUP_CYC - 1);
            dac_data <= wr_code;
          end else if (sd_valid) begin
            dac_sleep_n <= !sd_enter;
          end
        end
        S_SETUP: begin
          if (cnt_done) begin
            state    <= S_STROBE;
            cnt      <= CNT_W'(STROBE_CYC - 1);
            dac_cs_n <= 1'b0;
          end else cnt <= cnt - 1'b1;
        end
        S_STROBE: begin
          if (cnt_done) begin
            state       <= S_HOLD;
            cnt         <= CNT_W'(HOLD_CYC - 1);
            dac_cs_n    <= 1'b1;
            shadow_code <= dac_data;
          end else cnt <= cnt - 1'b1;
        end
        S_HOLD: begin
          if (cnt_done) state <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        S_CLEAR: begin
          if (cnt_done) begin
            state     <= S_IDLE;
            dac_clr_n <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_par_seq_chk.sv
module dac_par_seq_chk #(
  parameter int DATA_W        = 12,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_SETUP_NS    = 30,
  parameter int T_STROBE_NS   = 45,
  parameter int T_HOLD_NS     = 20,
  parameter int T_RESET_NS    = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              clr_valid,
  input logic [DATA_W-1:0] dac_data,
  input logic              dac_cs_n,
  input logic              dac_clr_n,
  input logic              dac_sleep_n,
  input logic [DATA_W-1:0] shadow_code
);
  function automatic int to_cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int SETUP_CYC  = to_cyc(T_SETUP_NS);
  localparam int STROBE_CYC = to_cyc(T_STROBE_NS);
  localparam int HOLD_CYC   = to_cyc(T_HOLD_NS);
  localparam int RESET_CYC  = to_cyc(T_RESET_NS);

  logic [15:0]       since_chg, rise_cnt, low_cnt, clr_cnt;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_chg <= '1;
      rise_cnt  <= '1;
      low_cnt   <= '0;
      clr_cnt   <= '0;
      data_q    <= '0;
    end else begin
      data_q <= dac_data;
      if (dac_data != data_q) since_chg <= 16'd1;
      else if (since_chg != '1) since_chg <= since_chg + 16'd1;
      if (!dac_cs_n) rise_cnt <= '0;
      else if (rise_cnt != '1) rise_cnt <= rise_cnt + 16'd1;
      if (!dac_cs_n) begin
        if (low_cnt != '1) low_cnt <= low_cnt + 16'd1;
      end else low_cnt <= '0;
      if (!dac_clr_n) begin
        if (clr_cnt != '1) clr_cnt <= clr_cnt + 16'd1;
      end else clr_cnt <= '0;
    end
  end

  p_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_cs_n) |-> since_chg >= 16'(SETUP_CYC));
  p_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_cs_n) |-> low_cnt == 16'(STROBE_CYC));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_data != data_q) |-> (dac_cs_n && rise_cnt >= 16'(HOLD_CYC)));
  p_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_cs_n |-> !req_ready);
  p_clr_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && clr_valid) |=> !dac_clr_n);
  p_clr_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_clr_n) |-> clr_cnt >= 16'(RESET_CYC));
  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_clr_n |-> dac_cs_n);
  p_shadow_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_clr_n |-> shadow_code == '0);
  p_sleep_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> $stable(dac_sleep_n));
  p_shadow_latch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_cs_n) |-> shadow_code == dac_data);
endmodule

bind dac_par_seq dac_par_seq_chk #(
  .DATA_W(DATA_W), .CLK_PERIOD_NS(CLK_PERIOD_NS), .T_SETUP_NS(T_SETUP_NS),
  .T_STROBE_NS(T_STROBE_NS), .T_HOLD_NS(T_HOLD_NS), .T_RESET_NS(T_RESET_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .clr_valid(clr_valid),
  .dac_data(dac_data), .dac_cs_n(dac_cs_n), .dac_clr_n(dac_clr_n),
  .dac_sleep_n(dac_sleep_n), .shadow_code(shadow_code)
);

// File: tb/dac_par_seq_bench.sv
module dac_par_seq_bench;
  localparam int W = 12;
  // R2: expected phase lengths at 8 ns: ceil(30/8)=4, ceil(45/8)=6, ceil(20/8)=3, ceil(40/8)=5
  localparam int E_SETUP = 4, E_STROBE = 6, E_HOLD = 3, E_CLR = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, clr_valid = 1'b0, sd_valid = 1'b0, sd_enter = 1'b0;
  logic [W-1:0] wr_code = '0;
  logic req_ready, dac_cs_n, dac_clr_n, dac_sleep_n;
  logic [W-1:0] dac_data, shadow_code;

  always #4 clk = ~clk;

  dac_par_seq u_dac_par_seq (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .wr_valid(wr_valid),
    .wr_code(wr_code), .clr_valid(clr_valid), .sd_valid(sd_valid),
    .sd_enter(sd_enter), .dac_data(dac_data), .dac_cs_n(dac_cs_n),
    .dac_clr_n(dac_clr_n), .dac_sleep_n(dac_sleep_n), .shadow_code(shadow_code)
  );

  int checks = 0, fails = 0;
  bit done = 0, armed = 0, have_rise = 0;
  int n_setup, n_low, n_hold, n_clr;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // converter register model with real-time checks
  logic [W-1:0] model;
  time t_data = 0, t_fall = 0, t_rise = 0, t_clr = 0;

  always @(negedge dac_clr_n) begin
    model = '0;
    t_clr = $time;
  end
  always @(posedge dac_clr_n)
    if (armed && ($time - t_clr) < 40) chk(0, "R8 clear pulse ns", int'($time - t_clr), 40);
  always @(negedge dac_cs_n) begin
    t_fall = $time;
    if (armed && dac_clr_n !== 1'b1) chk(0, "R8 strobe during clear", 0, 1);
  end
  always @(posedge dac_cs_n) begin
    if (dac_clr_n === 1'b1) model = dac_data;
    if (armed) begin
      if (($time - t_fall) < 45) chk(0, "R4 strobe ns", int'($time - t_fall), 45);
      if (($time - t_data) < 30) chk(0, "R3 setup ns", int'($time - t_data), 30);
      t_rise = $time;
      have_rise = 1;
    end
  end
  always @(dac_data) begin
    if (armed && dac_cs_n === 1'b0) chk(0, "R3 bus moved in strobe", 0, 1);
    if (armed && have_rise && ($time - t_rise) < 20) chk(0, "R5 hold ns", int'($time - t_rise), 20);
    t_data = $time;
  end

  task automatic track();
    bit seen = 0;
    n_setup = 0; n_low = 0; n_hold = 0; n_clr = 0;
    while (!req_ready) begin
      if (!dac_clr_n) n_clr++;
      else if (!dac_cs_n) begin n_low++; seen = 1; end
      else if (seen) n_hold++;
      else n_setup++;
      @(negedge clk);
    end
  endtask

  // op: 0 write, 1 clear, 2 sleep, 3 wake
  task automatic do_op(input logic [1:0] op, input logic [W-1:0] d);
    @(negedge clk);
    wr_valid = (op == 2'd0); clr_valid = (op == 2'd1);
    sd_valid = op[1]; sd_enter = (op == 2'd2); wr_code = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_valid = 0; clr_valid = 0; sd_valid = 0;
    track();
  endtask

  // {op, data, expected shadow, expected sleep_n}
  localparam int NV = 13;
  localparam logic [26:0] VEC [NV] = '{
    {2'd0, 12'h5A5, 12'h5A5, 1'b1},
    {2'd0, 12'h001, 12'h001, 1'b1},
    {2'd0, 12'hFFF, 12'hFFF, 1'b1},
    {2'd2, 12'h000, 12'hFFF, 1'b0},
    {2'd0, 12'h123, 12'h123, 1'b0},
    {2'd3, 12'h000, 12'h123, 1'b1},
    {2'd1, 12'hABC, 12'h000, 1'b1},
    {2'd0, 12'h800, 12'h800, 1'b1},
    {2'd0, 12'h800, 12'h800, 1'b1},
    {2'd2, 12'h000, 12'h800, 1'b0},
    {2'd1, 12'h000, 12'h000, 1'b0},
    {2'd3, 12'h000, 12'h000, 1'b1},
    {2'd0, 12'h7FF, 12'h7FF, 1'b1}
  };

  initial begin
    #(8 * 100000);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1; armed = 1;
    @(negedge clk);
    // R1: power-up clear in progress
    chk(dac_clr_n == 0 && req_ready == 0, "R1 clear after release", {dac_clr_n, req_ready}, 0);
    chk(shadow_code == 0 && dac_cs_n && dac_sleep_n, "R1 idle pins", shadow_code, 0);
    track();
    chk(n_clr == E_CLR - 1, "R1 clear length after release", n_clr, E_CLR - 1);
    chk(dac_clr_n && model == 0, "R1 model zero", model, 0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; logic [W-1:0] d, e; logic sl;
      {op, d, e, sl} = VEC[i];
      do_op(op, d);
      chk(shadow_code == e, $sformatf("R11 shadow vec %0d", i), shadow_code, e);
      chk(model == e, $sformatf("R11 latched vec %0d", i), model, e);
      chk(dac_sleep_n == sl, $sformatf("R9 R10 sleep vec %0d", i), dac_sleep_n, sl);
      if (op == 2'd0) begin
        chk(n_setup == E_SETUP, "R3 setup cycles", n_setup, E_SETUP);
        chk(n_low == E_STROBE, "R4 strobe cycles", n_low, E_STROBE);
        chk(n_hold == E_HOLD, "R5 hold cycles", n_hold, E_HOLD);
        chk(dac_data == d, "R12 bus bits", dac_data, d);
      end else if (op == 2'd1) begin
        chk(n_clr == E_CLR && n_low == 0, "R8 clear cycles", n_clr, E_CLR);
      end else begin
        chk(n_setup + n_low + n_clr == 0 && req_ready, "R9 one-cycle shutdown op", n_setup, 0);
      end
    end

    // R7: clear and write together
    @(negedge clk);
    wr_code = 12'h3C3; wr_valid = 1; clr_valid = 1;
    @(posedge clk);
    @(negedge clk);
    clr_valid = 0;
    chk(!dac_clr_n && dac_cs_n && !req_ready, "R7 clear taken first", {dac_clr_n, dac_cs_n}, 1);
    track();
    chk(n_clr == E_CLR && model == 0, "R7 clear done before write", model, 0);
    @(posedge clk);
    @(negedge clk);
    wr_valid = 0;
    chk(!req_ready && dac_data == 12'h3C3, "R6 pending write taken", dac_data, 12'h3C3);
    track();
    chk(model == 12'h3C3 && shadow_code == 12'h3C3, "R7 write after clear", model, 12'h3C3);

    // R9: shutdown waits behind a write
    @(negedge clk);
    wr_code = 12'h0F0; wr_valid = 1; sd_valid = 1; sd_enter = 1;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 0;
    chk(dac_sleep_n == 1 && !req_ready, "R9 shutdown lower priority", dac_sleep_n, 1);
    track();
    @(posedge clk);
    @(negedge clk);
    sd_valid = 0;
    chk(dac_sleep_n == 0 && model == 12'h0F0, "R9 R10 shutdown after write", model, 12'h0F0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule